// File: doc/BRIEF.md
# Cascaded Timer Pair with Capture Contention

This block joins two 16-bit counters into one 32-bit count chain. The lower counter (channel 2) counts every clock while the block runs, upward or downward as a control bit selects. Each time it wraps, it sends a count pulse to the upper counter (channel 1). A wrap upward moves channel 1 up by one, and a wrap downward moves it down by one. Channel 1 has a compare register A, a capture register B and a buffer that receives the previous contents of B on every capture. A third unit (channel 0) runs its own free counter. When enabled, it latches that counter into all four of its capture registers on each cascade pulse.

Software writes the registers through a two-phase port. The address is presented in the first cycle, and the data with its strobe in the second. A combinational read port returns any register. The block resolves same-cycle conflicts with fixed rules. A write to the lower counter beats the cascade pulse, but the compare check and the channel-0 capture still see that pulse. A capture into register B beats a bus write to B or to its buffer.

Top module: `casc_timer_pair`

## Requirements
- R1: After synchronous active-low reset, every readable register (addresses 0 to 11) reads as zero.
- R2: A write takes two cycles. In the first, `bus_sel` presents `bus_addr`. In the next, `bus_we` presents `bus_wdata`, which lands on that cycle's clock edge. A `bus_we` with no `bus_sel` in the preceding cycle is ignored. The address map is: 0 control, 1 status, 2 channel-2 counter, 3 channel-1 counter, 4 compare A, 5 capture B, 6 buffer, 7 channel-0 counter, 8 to 11 channel-0 capture registers (read only). `rd_data` shows the register at `rd_addr` in the same cycle.
- R3: When control bit 0 (run) is 1, the channel-2 counter changes once per clock. It counts down when control bit 1 is 1 and up otherwise, and wraps between 0xFFFF and 0x0000.
- R4: A channel-2 overflow (0xFFFF to 0x0000) adds one to the channel-1 counter, and an underflow (0x0000 to 0xFFFF) subtracts one. Channel 1 itself wraps modulo 2^16.
- R5: If a channel-2 counter write lands in the same cycle as a channel-2 wrap, the written value is kept and channel 1 does not change in that cycle.
- R6: On every cycle with a channel-2 wrap, including one whose pulse R5 suppresses, status bit 0 is set if the channel-1 counter equals compare A. The bit stays set until a status write with bit 0 equal to 0 clears it. Writing 1 leaves it set.
- R7: A capture into register B loads the channel-1 counter into B and moves the old B into the buffer in the same cycle. The capture source is set by control bit 4: 0 selects the pin edge, and 1 selects the R6 compare event.
- R8: `cap_pin` passes through a two-flop synchronizer. Control bit 2 picks the capturing edge: 0 for rising, 1 for falling. The other edge has no effect. A pin change made before clock edge k is captured at edge k+2.
- R9: A capture into B in the same cycle as a bus write to B or to the buffer wins, and the write is dropped.
- R10: The channel-0 counter counts up once per clock while run is 1. When control bit 3 is 1, every channel-2 wrap, including a suppressed one, loads that counter into all four channel-0 capture registers.
- R11: When control bit 5 is 1, a compare event clears both the channel-1 and channel-2 counters at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Address phase strobe |
| bus_addr | input | 4 | Register address, first phase |
| bus_we | input | 1 | Data phase write strobe |
| bus_wdata | input | 16 | Write data, second phase |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data, combinational |
| cap_pin | input | 1 | Asynchronous capture pin |

## Verification
The cascade is driven with the lower counter parked one step before a wrap in each direction. It is then started with a write that is pipelined so that the following counter write, or an idle cycle, falls exactly on the wrap cycle. Comparing the contended and idle cases shows whether the write or the pulse wins. Matching against non-matching compare values shows whether the compare and the channel-0 capture still see a suppressed pulse. Pin edges are timed so that a write to register B or to its buffer lands on the capture cycle, which separates capture priority from plain write-back. The wrong-edge and strobe-without-address patterns confirm that the selected edge and the two-phase rule are obeyed.

// File: rtl/casc_timer_pkg.sv
`timescale 1ns/1ps
// Package: shared register addresses and the control word layout for the
// cascaded timer pair. Assumes a 4-bit address space and W >= 6.
package casc_timer_pkg;

    localparam int ADR_CTRL  = 0;
    localparam int ADR_STAT  = 1;
    localparam int ADR_CNT2  = 2;
    localparam int ADR_CNT1  = 3;
    localparam int ADR_GRA1  = 4;
    localparam int ADR_GRB1  = 5;
    localparam int ADR_BUF1  = 6;
    localparam int ADR_CNT0  = 7;
    localparam int ADR_CAP0  = 8;
    localparam int CTRL_BITS = 6;

    // Control word, bit 0 at the bottom.
    typedef struct packed {
        logic clr_sync;     // bit 5: compare event clears both counters
        logic grb_src_cmp;  // bit 4: register B captures on compare event
        logic ch0_cap_en;   // bit 3: channel 0 captures on cascade pulse
        logic edge_fall;    // bit 2: pin capture on falling edge
        logic ch2_down;     // bit 1: lower counter counts down
        logic run;          // bit 0: counters enabled
    } ctrl_t;

endpackage

// File: rtl/casc_bus_port.sv
`timescale 1ns/1ps
// Module: two-phase write port. The address phase latches the address, and
// the data phase fires a one-cycle write strobe. Assumes at most one write
// in flight. An address phase may overlap the previous data phase.
module casc_bus_port #(
    parameter int AW = 4,
    parameter int W  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [W-1:0]  bus_wdata,
    output logic          wr_fire,
    output logic [AW-1:0] wr_addr,
    output logic [W-1:0]  wr_data
);

    logic          pend_q;
    logic [AW-1:0] addr_q;

    // Records the address phase so the next cycle may complete the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            addr_q <= '0;
        end else begin
            pend_q <= bus_sel;
            if (bus_sel) begin
                addr_q <= bus_addr;
            end
        end
    end

    // Fires the write only when an address phase preceded the strobe.
    always_comb begin
        wr_fire = bus_we & pend_q;
        wr_addr = addr_q;
        wr_data = bus_wdata;
    end

endmodule

// File: rtl/casc_sync_edge.sv
`timescale 1ns/1ps
// Module: synchronizes an asynchronous pin with two flops and emits a
// one-cycle pulse on the selected edge. Assumes the pin holds each level
// for at least two clocks.
module casc_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_pulse
);

    logic s1_q, s2_q, s3_q;

    // Synchronizer chain, plus one delayed copy used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // Selects which transition of the synchronized level makes a pulse.
    always_comb begin
        edge_pulse = fall_sel ? (s3_q & ~s2_q) : (s2_q & ~s3_q);
    end

endmodule

// File: rtl/casc_updn_cnt.sv
`timescale 1ns/1ps
// Module: loadable up/down counter. A load beats counting. Wrap detection
// is left to the instantiating logic.
module casc_updn_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         down,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] STEP = W'(1);

    // Holds, loads or steps the count each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (en) begin
            cnt <= down ? (cnt - STEP) : (cnt + STEP);
        end
    end

endmodule

// File: rtl/casc_cap_bank.sv
`timescale 1ns/1ps
// Module: bank of N capture registers that all latch the same input value
// on a shared capture strobe. Assumes the registers are read only.
module casc_cap_bank #(
    parameter int W = 16,
    parameter int N = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap,
    input  logic [W-1:0]        din,
    output logic [N-1:0][W-1:0] regs_q
);

    for (genvar g = 0; g < N; g++) begin : g_reg
        // One capture register of the bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (cap) begin
                regs_q[g] <= din;
            end
        end
    end

endmodule

// File: rtl/casc_timer_pair.sv
`timescale 1ns/1ps
// Module: cascaded timer pair. Channel 2 counts every clock, and each of its
// wraps steps channel 1. Channel 1 has compare A, capture B and a buffer
// behind B. Channel 0 captures its own counter on the cascade pulse.
// Contention rules: a counter write beats the cascade pulse. Compare and
// channel-0 capture still see a suppressed pulse. A capture beats writes to
// B and to the buffer. Assumes W >= 6 and 2**AW >= 8 + N_CAP0.
module casc_timer_pair
    import casc_timer_pkg::*;
#(
    parameter int W      = 16,
    parameter int N_CAP0 = 4,
    parameter int AW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [W-1:0]  bus_wdata,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    input  logic          cap_pin
);

    localparam int PAD = W - CTRL_BITS;

    logic          wr_fire;
    logic [AW-1:0] wr_addr;
    logic [W-1:0]  wr_data;
    logic wr_ctrl, wr_stat, wr_cnt2, wr_cnt1, wr_gra1, wr_grb1, wr_buf1, wr_cnt0;

    ctrl_t         ctrl_q;
    logic          cmp_flag_q;
    logic [W-1:0]  gra1_q, grb1_q, buf1_q;
    logic [W-1:0]  cnt2, cnt1, cnt0;
    logic          ch2_ovf, ch2_unf, casc_raw, cmp_evt, clr_evt;
    logic          pin_edge, grb_cap, cap0_fire;
    logic          ld2, ld1;
    logic [W-1:0]  ld2_val, ld1_val;
    logic [N_CAP0-1:0][W-1:0] cap0_q;

    casc_bus_port #(.AW(AW), .W(W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .wr_fire   (wr_fire),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    // Decodes the completed write into per-register strobes.
    always_comb begin
        wr_ctrl = wr_fire && (int'(wr_addr) == ADR_CTRL);
        wr_stat = wr_fire && (int'(wr_addr) == ADR_STAT);
        wr_cnt2 = wr_fire && (int'(wr_addr) == ADR_CNT2);
        wr_cnt1 = wr_fire && (int'(wr_addr) == ADR_CNT1);
        wr_gra1 = wr_fire && (int'(wr_addr) == ADR_GRA1);
        wr_grb1 = wr_fire && (int'(wr_addr) == ADR_GRB1);
        wr_buf1 = wr_fire && (int'(wr_addr) == ADR_BUF1);
        wr_cnt0 = wr_fire && (int'(wr_addr) == ADR_CNT0);
    end

    // Detects channel-2 wraps and derives the events the cascade drives.
    always_comb begin
        ch2_ovf  = ctrl_q.run & ~ctrl_q.ch2_down & (cnt2 == '1);
        ch2_unf  = ctrl_q.run &  ctrl_q.ch2_down & (cnt2 == '0);
        casc_raw = ch2_ovf | ch2_unf;
        cmp_evt  = casc_raw & (cnt1 == gra1_q);
        clr_evt  = ctrl_q.clr_sync & cmp_evt;
        grb_cap  = ctrl_q.grb_src_cmp ? cmp_evt : pin_edge;
        cap0_fire = ctrl_q.ch0_cap_en & casc_raw;
    end

    // Load selection for both cascade counters: a bus write beats a clear.
    always_comb begin
        ld2     = wr_cnt2 | clr_evt;
        ld2_val = wr_cnt2 ? wr_data : '0;
        ld1     = wr_cnt1 | clr_evt;
        ld1_val = wr_cnt1 ? wr_data : '0;
    end

    casc_updn_cnt #(.W(W)) u_cnt2 (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ctrl_q.run),
        .down   (ctrl_q.ch2_down),
        .ld     (ld2),
        .ld_val (ld2_val),
        .cnt    (cnt2)
    );

    casc_updn_cnt #(.W(W)) u_cnt1 (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (casc_raw & ~wr_cnt2),
        .down   (ch2_unf),
        .ld     (ld1),
        .ld_val (ld1_val),
        .cnt    (cnt1)
    );

    casc_updn_cnt #(.W(W)) u_cnt0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ctrl_q.run),
        .down   (1'b0),
        .ld     (wr_cnt0),
        .ld_val (wr_data),
        .cnt    (cnt0)
    );

    casc_sync_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin        (cap_pin),
        .fall_sel   (ctrl_q.edge_fall),
        .edge_pulse (pin_edge)
    );

    casc_cap_bank #(.W(W), .N(N_CAP0)) u_cap0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap    (cap0_fire),
        .din    (cnt0),
        .regs_q (cap0_q)
    );

    // Control word and compare register A.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            gra1_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= ctrl_t'(wr_data[CTRL_BITS-1:0]);
            end
            if (wr_gra1) begin
                gra1_q <= wr_data;
            end
        end
    end

    // Sticky compare flag: setting beats a clear written in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_flag_q <= 1'b0;
        end else if (cmp_evt) begin
            cmp_flag_q <= 1'b1;
        end else if (wr_stat) begin
            cmp_flag_q <= cmp_flag_q & wr_data[0];
        end
    end

    // Capture register B and its buffer: a capture beats bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grb1_q <= '0;
            buf1_q <= '0;
        end else if (grb_cap) begin
            grb1_q <= cnt1;
            buf1_q <= grb1_q;
        end else begin
            if (wr_grb1) begin
                grb1_q <= wr_data;
            end
            if (wr_buf1) begin
                buf1_q <= wr_data;
            end
        end
    end

    // Combinational read multiplexer.
    always_comb begin
        rd_data = '0;
        case (int'(rd_addr))
            ADR_CTRL: rd_data = {{PAD{1'b0}}, ctrl_q};
            ADR_STAT: rd_data = {{(W-1){1'b0}}, cmp_flag_q};
            ADR_CNT2: rd_data = cnt2;
            ADR_CNT1: rd_data = cnt1;
            ADR_GRA1: rd_data = gra1_q;
            ADR_GRB1: rd_data = grb1_q;
            ADR_BUF1: rd_data = buf1_q;
            ADR_CNT0: rd_data = cnt0;
            default: begin
                for (int i = 0; i < N_CAP0; i++) begin
                    if (int'(rd_addr) == ADR_CAP0 + i) begin
                        rd_data = cap0_q[i];
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/casc_timer_pair_chk.sv
`timescale 1ns/1ps
// Module: assertion checker bound to the cascaded timer pair. It observes
// the write strobes, wrap events and register state across clock edges.
module casc_timer_pair_chk
    import casc_timer_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_fire,
    input logic [AW-1:0] wr_addr,
    input logic [W-1:0]  wr_data,
    input logic          ch2_ovf,
    input logic          ch2_unf,
    input logic          clr_evt,
    input logic [W-1:0]  cnt2,
    input logic [W-1:0]  cnt1,
    input logic [W-1:0]  cnt0,
    input logic          grb_cap,
    input logic [W-1:0]  grb1_q,
    input logic [W-1:0]  buf1_q,
    input logic          cap0_fire,
    input logic [W-1:0]  cap0_a,
    input logic          cmp_flag_q
);

    localparam logic [W-1:0] ONE = W'(1);

    logic c_wr_cnt2, c_wr_cnt1, c_wr_stat;

    // Local decode of the write address.
    always_comb begin
        c_wr_cnt2 = wr_fire && (int'(wr_addr) == ADR_CNT2);
        c_wr_cnt1 = wr_fire && (int'(wr_addr) == ADR_CNT1);
        c_wr_stat = wr_fire && (int'(wr_addr) == ADR_STAT);
    end

    assert_ovf_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ch2_ovf && !c_wr_cnt2) |=> (cnt2 == '0));

    assert_unf_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ch2_unf && !c_wr_cnt2 && !clr_evt) |=> (cnt2 == '1));

    assert_casc_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ch2_ovf && !c_wr_cnt2 && !c_wr_cnt1 && !clr_evt) |=> (cnt1 == $past(cnt1) + ONE));

    assert_casc_dn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ch2_unf && !c_wr_cnt2 && !c_wr_cnt1 && !clr_evt) |=> (cnt1 == $past(cnt1) - ONE));

    assert_wr_beats_casc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch2_ovf || ch2_unf) && c_wr_cnt2 && !clr_evt)
        |=> ((cnt1 == $past(cnt1)) && (cnt2 == $past(wr_data))));

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag_q && !(c_wr_stat && !wr_data[0])) |=> cmp_flag_q);

    assert_cap_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
        grb_cap |=> ((buf1_q == $past(grb1_q)) && (grb1_q == $past(cnt1))));

    assert_ch0_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cap0_fire |=> (cap0_a == $past(cnt0)));

    assert_clr_pair_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !c_wr_cnt1 && !c_wr_cnt2) |=> ((cnt1 == '0) && (cnt2 == '0)));

endmodule

bind casc_timer_pair casc_timer_pair_chk #(.W(W), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_fire),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .ch2_ovf    (ch2_ovf),
    .ch2_unf    (ch2_unf),
    .clr_evt    (clr_evt),
    .cnt2       (cnt2),
    .cnt1       (cnt1),
    .cnt0       (cnt0),
    .grb_cap    (grb_cap),
    .grb1_q     (grb1_q),
    .buf1_q     (buf1_q),
    .cap0_fire  (cap0_fire),
    .cap0_a     (cap0_q[0]),
    .cmp_flag_q (cmp_flag_q)
);

// File: tb/casc_timer_pair_tb.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random trials of the cascade and
// the capture contention, checked against expected values computed here.
module casc_timer_pair_tb;

    localparam int A_CTRL = 0, A_STAT = 1, A_CNT2 = 2, A_CNT1 = 3, A_GRA1 = 4;
    localparam int A_GRB1 = 5, A_BUF1 = 6, A_CNT0 = 7, A_CAP0 = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        cap_pin = 1'b0;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;
    logic [15:0] exp_gr0 = '0;

    casc_timer_pair u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .cap_pin   (cap_pin)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rchk(input int a, input logic [15:0] exp, input string req);
        rd_addr = 4'(a);
        #0.1;
        chk(req, rd_data, exp);
    endtask

    // Two-phase write, called and returning just after a falling edge.
    task automatic wr(input int a, input logic [15:0] d);
        bus_sel = 1'b1; bus_addr = 4'(a);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    function automatic logic [15:0] exp_cnt1(bit dn, bit con, bit clr,
                                             logic [15:0] c1, logic [15:0] g1);
        if (clr && (c1 == g1)) return 16'h0000;
        if (con) return c1;
        return dn ? c1 - 16'd1 : c1 + 16'd1;
    endfunction

    function automatic logic [15:0] exp_cnt2(bit dn, bit con, logic [15:0] wd);
        if (con) return wd;
        return dn ? 16'hFFFF : 16'h0000;
    endfunction

    // Parks channel 2 one step before a wrap, then starts it with a write
    // that is pipelined so the wrap cycle either meets a counter write (con)
    // or stays idle.
    task automatic casc_trial(input bit dn, input bit con, input bit clr,
                              input bit c0en, input bit gsrc,
                              input logic [15:0] c1, input logic [15:0] g1,
                              input logic [15:0] gb, input logic [15:0] c0,
                              input logic [15:0] wd);
        logic [15:0] ctl;
        bit match;
        match = (c1 == g1);
        ctl = {10'd0, clr, gsrc, c0en, 1'b0, dn, 1'b1};
        wr(A_CTRL, 16'h0000);
        wr(A_STAT, 16'h0000);
        wr(A_CNT2, dn ? 16'h0000 : 16'hFFFF);
        wr(A_CNT1, c1);
        wr(A_GRA1, g1);
        wr(A_GRB1, gb);
        wr(A_BUF1, 16'h0000);
        wr(A_CNT0, c0);
        bus_sel = 1'b1; bus_addr = 4'(A_CTRL);
        @(negedge clk);
        bus_sel = con; bus_addr = 4'(A_CNT2); bus_we = 1'b1; bus_wdata = ctl;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = con; bus_wdata = wd;
        @(negedge clk);
        bus_we = 1'b0;
        if (clr) begin
            rchk(A_CNT2, (match && !con) ? 16'h0000 : exp_cnt2(dn, con, wd), "R11 cnt2");
        end else begin
            rchk(A_CNT2, exp_cnt2(dn, con, wd), con ? "R5 cnt2 write wins" : "R3 cnt2 wrap");
        end
        rchk(A_CNT1, exp_cnt1(dn, con, clr, c1, g1),
             clr ? "R11 cnt1 clear" : (con ? "R5 cnt1 held" : "R4 cnt1 step"));
        rchk(A_STAT, {15'd0, match}, "R6 compare flag");
        rchk(A_GRB1, (gsrc && match) ? c1 : gb, "R7 capture B");
        rchk(A_BUF1, (gsrc && match) ? gb : 16'h0000, "R7 buffer");
        if (c0en) exp_gr0 = c0;
        for (int i = 0; i < 4; i++) rchk(A_CAP0 + i, exp_gr0, "R10 ch0 capture");
        rchk(A_CNT0, c0 + 16'd1, "R10 ch0 counter");
        wr(A_CTRL, 16'h0000);
    endtask

    // Pin capture, with an optional bus write to B or the buffer timed to
    // land in the capture cycle.
    task automatic pin_trial(input bit fall, input bit con, input bit tgt_buf,
                             input logic [15:0] c1, input logic [15:0] gb,
                             input logic [15:0] bb, input logic [15:0] wd);
        wr(A_CTRL, fall ? 16'h0004 : 16'h0000);
        cap_pin = fall;
        repeat (4) @(negedge clk);
        wr(A_CNT1, c1);
        wr(A_GRB1, gb);
        wr(A_BUF1, bb);
        cap_pin = ~fall;
        @(negedge clk);
        bus_sel = con; bus_addr = tgt_buf ? 4'(A_BUF1) : 4'(A_GRB1);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = con; bus_wdata = wd;
        rchk(A_GRB1, gb, "R8 not yet captured");
        @(negedge clk);
        bus_we = 1'b0;
        rchk(A_GRB1, c1, con ? "R9 capture beats write B" : "R8 capture latency");
        rchk(A_BUF1, gb, con ? "R9 capture beats write buf" : "R7 old B to buffer");
    endtask

    initial begin
        logic [15:0] v;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of every address
        for (int a = 0; a < 12; a++) rchk(a, 16'h0000, "R1 reset");

        // R2: two-phase write and strobe without address phase
        wr(A_GRA1, 16'h1357);
        rchk(A_GRA1, 16'h1357, "R2 write");
        bus_we = 1'b1; bus_wdata = 16'hFFFF;
        @(negedge clk);
        bus_we = 1'b0;
        rchk(A_GRA1, 16'h1357, "R2 lone strobe ignored");
        wr(A_CTRL, 16'h0018);
        rchk(A_CTRL, 16'h0018, "R2 ctrl readback");

        // R3: counting up and wrapping down
        wr(A_CTRL, 16'h0000);
        wr(A_CNT2, 16'd10);
        wr(A_CTRL, 16'h0001);
        rchk(A_CNT2, 16'd10, "R3 start");
        repeat (5) @(negedge clk);
        rchk(A_CNT2, 16'd15, "R3 up count");
        wr(A_CTRL, 16'h0000);
        wr(A_CNT2, 16'd3);
        wr(A_CTRL, 16'h0003);
        repeat (5) @(negedge clk);
        rchk(A_CNT2, 16'hFFFE, "R3 down wrap");
        wr(A_CTRL, 16'h0000);

        // Directed cascade corners
        casc_trial(0, 0, 0, 1, 1, 16'h0041, 16'h0041, 16'h0A0A, 16'h0200, 16'h0000);
        casc_trial(0, 1, 0, 1, 1, 16'h0077, 16'h0077, 16'h0B0B, 16'h0300, 16'h1234);
        casc_trial(1, 1, 0, 1, 1, 16'h0010, 16'h0010, 16'h0C0C, 16'h0400, 16'h4321);
        casc_trial(1, 0, 0, 0, 0, 16'h0000, 16'h5555, 16'h0D0D, 16'h0500, 16'h0000);
        casc_trial(0, 0, 0, 0, 0, 16'hFFFF, 16'h5555, 16'h0E0E, 16'h0600, 16'h0000);
        casc_trial(0, 0, 1, 0, 0, 16'h0123, 16'h0123, 16'h0F0F, 16'h0700, 16'h0000);

        // R6: writing 1 keeps the flag, writing 0 clears it
        rchk(A_STAT, 16'h0001, "R6 flag held");
        wr(A_STAT, 16'h0001);
        rchk(A_STAT, 16'h0001, "R6 write one keeps");
        wr(A_STAT, 16'h0000);
        rchk(A_STAT, 16'h0000, "R6 write zero clears");

        // Random cascade trials
        for (int k = 0; k < 24; k++) begin
            logic [15:0] c1, g1;
            c1 = 16'($urandom);
            g1 = ($urandom % 2) ? c1 : (c1 ^ 16'h0101);
            casc_trial(1'($urandom), 1'($urandom), 0, 1'($urandom), 1'($urandom),
                       c1, g1, 16'($urandom), 16'($urandom % 16'hF000),
                       16'h0100 + 16'($urandom % 16'hE000));
        end

        // Pin capture: directed, then random contention
        pin_trial(0, 0, 0, 16'h2222, 16'h3333, 16'h4444, 16'h0000);
        pin_trial(1, 1, 1, 16'h5151, 16'h6262, 16'h7373, 16'h9999);
        pin_trial(0, 1, 0, 16'hA1A1, 16'hB2B2, 16'hC3C3, 16'h8888);
        for (int k = 0; k < 8; k++) begin
            pin_trial(1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
                      16'($urandom), 16'($urandom), 16'($urandom));
        end

        // R8: the non-selected edge does not capture
        wr(A_CTRL, 16'h0000);
        cap_pin = 1'b1;
        repeat (4) @(negedge clk);
        wr(A_CNT1, 16'h0F0F);
        wr(A_GRB1, 16'h1F1F);
        cap_pin = 1'b0;
        repeat (5) @(negedge clk);
        rchk(A_GRB1, 16'h1F1F, "R8 wrong edge ignored");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule